// File: doc/BRIEF.md
# Sticky Error Interrupt Controller

This block gathers five error event lines from a codec-style audio datapath and keeps a sticky record of each one. The five lines are test-mode entry, serial port framing, clocking, ADC overflow and DAC clip. A bit is recorded only when its line rises, not while the line stays high. A set bit therefore means the error happened at some point since the host last cleared the record. It does not mean the error is present now.

The host reaches two registers through a small read/write port. The first holds the notifications, and reading it also clears them. The second holds the per-source masks. An active-low interrupt line is asserted while any recorded source is unmasked. Masking never stops a bit from being recorded.

Two sources are treated as severe: serial port errors and clocking errors. Either one raises a mute request at once. The mute then acts as a recovery lock: it stays asserted until every power-down control has been driven high and afterwards driven low again.

Top module: `err_irq_ctrl`

## Requirements
- R1: Each event input is registered once. A rising edge on bit i of `err_evt_i` sets notification bit i on the second clock edge after the input rises. Bit positions: 0 test-mode entry, 1 serial port, 2 clocking, 3 ADC overflow, 4 DAC clip.
- R2: An input held high sets its notification bit only once. After the bit is cleared it stays clear while the input remains high.
- R3: A notification bit is recorded whatever the state of its mask bit.
- R4: `irq_n_o` is low exactly while some notification bit is set whose mask bit is 0.
- R5: A read at address 0 returns the notification bits on `reg_rdata_o[4:0]` in the same cycle. All notification bits are cleared at the clock edge that ends the read.
- R6: If an event edge falls in the same cycle as a notification clear, that event's bit is set after the edge.
- R7: An edge on the serial port or clocking source raises `mute_o` on the same clock edge that sets its notification bit. The other three sources never raise `mute_o`.
- R8: Once raised, `mute_o` stays high until all `pdn_i` bits have been sampled high and then all have been sampled low. It falls on the edge at which the all-low condition is sampled. Partial patterns and notification reads leave it high.
- R9: After reset, the notification bits and the mask bits are all 0, `mute_o` is 0 and `irq_n_o` is 1.
- R10: Address 1 is the read/write mask register: bit i masks source i and bits above 4 read as 0. A write to address 0 has no effect.
- R11: A mute-class event that arrives while recovery is in progress restarts the sequence. A fresh all-high then all-low pass is needed after that event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_evt_i | input | 5 | Error event lines, one per source |
| pdn_i | input | 4 | Power-down controls used for recovery |
| reg_addr_i | input | 2 | Register address (0 notification, 1 mask) |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, combinational from the address |
| irq_n_o | output | 1 | Active-low interrupt |
| mute_o | output | 1 | Mute request and recovery lock |

## Verification
A corrupted notification bit shows up at `irq_n_o` in the same cycle when the source is unmasked. For a masked source it shows up only on the next read of address 0. A lost edge-history register makes a held input set its bit again on the cycle after a clear, which the next read exposes. A wrong recovery state shows at `mute_o` one edge after the power-down pattern that should have moved it, either as a mute that never releases or as one that releases too early.

// File: rtl/err_irq_pkg.sv
package err_irq_pkg;
  localparam int NSRC = 5;

  localparam int SRC_TEST  = 0;
  localparam int SRC_SPORT = 1;
  localparam int SRC_CLK   = 2;
  localparam int SRC_ADC   = 3;
  localparam int SRC_DAC   = 4;

  // Sources that force a mute and demand a power-down cycle
  localparam logic [NSRC-1:0] MUTE_SRC = (NSRC'(1) << SRC_SPORT) | (NSRC'(1) << SRC_CLK);

  typedef enum logic [1:0] {
    RC_IDLE     = 2'd0,
    RC_WAIT_SET = 2'd1,
    RC_WAIT_CLR = 2'd2
  } rcv_state_t;

  function automatic logic [NSRC-1:0] pending_irq(input logic [NSRC-1:0] flags,
                                                  input logic [NSRC-1:0] mask);
    return flags & ~mask;
  endfunction

  function automatic logic [NSRC-1:0] flag_update(input logic [NSRC-1:0] flags,
                                                  input logic            clr,
                                                  input logic [NSRC-1:0] rise);
    return (clr ? '0 : flags) | rise;
  endfunction
endpackage

// File: rtl/err_event_capture.sv
module err_event_capture #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt_i,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] cur_q;
  logic [N-1:0] prev_q;

  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_src
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          cur_q[gi]  <= 1'b0;
          prev_q[gi] <= 1'b0;
        end else begin
          cur_q[gi]  <= evt_i[gi];
          prev_q[gi] <= cur_q[gi];
        end
      end

      assign rise_o[gi] = cur_q[gi] & ~prev_q[gi];

      // R2: a detected edge never repeats on the following cycle
      assert_single_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o[gi] |=> !rise_o[gi]);
    end
  endgenerate
endmodule

// File: rtl/err_sticky_flags.sv
module err_sticky_flags
  import err_irq_pkg::*;
#(
  parameter int N = NSRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] rise_i,
  input  logic         clr_i,
  output logic [N-1:0] flags_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) flags_o <= '0;
    else        flags_o <= flag_update(flags_o, clr_i, rise_i);
  end

  // R1 / R6: every detected edge is recorded, even against a clear
  assert_edge_recorded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise_i) |=> ((flags_o & $past(rise_i)) == $past(rise_i)));

  // R5: a clear with no competing edge empties the record
  assert_clear_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && rise_i == '0) |=> (flags_o == '0));
endmodule

// File: rtl/err_recovery_lock.sv
module err_recovery_lock
  import err_irq_pkg::*;
#(
  parameter int N_PDN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_i,
  input  logic [N_PDN-1:0] pdn_i,
  output logic             mute_o
);
  rcv_state_t state_q, state_d;
  logic pdn_all_set, pdn_all_clr;

  assign pdn_all_set = &pdn_i;
  assign pdn_all_clr = ~|pdn_i;

  always_comb begin
    state_d = state_q;
    if (trig_i) begin
      state_d = RC_WAIT_SET;
    end else begin
      case (state_q)
        RC_WAIT_SET: if (pdn_all_set) state_d = RC_WAIT_CLR;
        RC_WAIT_CLR: if (pdn_all_clr) state_d = RC_IDLE;
        default:     state_d = RC_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= RC_IDLE;
    else        state_q <= state_d;
  end

  assign mute_o = (state_q != RC_IDLE);

  // R7: mute only rises after a mute-class trigger
  assert_mute_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mute_o) |-> $past(trig_i));

  // R8: mute only releases after all power-down bits were seen low
  assert_mute_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mute_o) |-> $past(pdn_all_clr));
endmodule

// File: rtl/err_irq_ctrl.sv
module err_irq_ctrl
  import err_irq_pkg::*;
#(
  parameter int N_PDN = 4,
  parameter int AW    = 2,
  parameter int DW    = 8,
  parameter logic [AW-1:0] ADDR_NOTIF = 0,
  parameter logic [AW-1:0] ADDR_MASK  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  err_evt_i,
  input  logic [N_PDN-1:0] pdn_i,
  input  logic [AW-1:0]    reg_addr_i,
  input  logic             reg_wr_i,
  input  logic             reg_rd_i,
  input  logic [DW-1:0]    reg_wdata_i,
  output logic [DW-1:0]    reg_rdata_o,
  output logic             irq_n_o,
  output logic             mute_o
);
  logic [NSRC-1:0] rise;
  logic [NSRC-1:0] flags;
  logic [NSRC-1:0] mask_q;
  logic            rd_clr;
  logic            mask_wr;
  logic            mute_trig;

  err_event_capture #(.N(NSRC)) u_capture (
    .clk   (clk),
    .rst_n (rst_n),
    .evt_i (err_evt_i),
    .rise_o(rise)
  );

  assign rd_clr  = reg_rd_i && (reg_addr_i == ADDR_NOTIF);
  assign mask_wr = reg_wr_i && (reg_addr_i == ADDR_MASK);

  err_sticky_flags #(.N(NSRC)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .rise_i (rise),
    .clr_i  (rd_clr),
    .flags_o(flags)
  );

  assign mute_trig = |(rise & MUTE_SRC);

  err_recovery_lock #(.N_PDN(N_PDN)) u_recovery (
    .clk   (clk),
    .rst_n (rst_n),
    .trig_i(mute_trig),
    .pdn_i (pdn_i),
    .mute_o(mute_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_wr) mask_q <= reg_wdata_i[NSRC-1:0];
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_NOTIF)     reg_rdata_o[NSRC-1:0] = flags;
    else if (reg_addr_i == ADDR_MASK) reg_rdata_o[NSRC-1:0] = mask_q;
  end

  assign irq_n_o = ~|pending_irq(flags, mask_q);

  // R4: the interrupt is only withdrawn by a clearing read or a mask change
  assert_irq_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_n_o) |-> $past(rd_clr || mask_wr));

  // R3: an edge on an unmasked source always reaches the interrupt line
  assert_unmasked_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|(rise & ~mask_q) && !mask_wr) |=> !irq_n_o);
endmodule

// File: tb/err_irq_ctrl_bench.sv
module err_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [4:0] err_evt_i;
  logic [3:0] pdn_i;
  logic [1:0] reg_addr_i;
  logic       reg_wr_i, reg_rd_i;
  logic [7:0] reg_wdata_i;
  logic [7:0] reg_rdata_o;
  logic       irq_n_o, mute_o;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  err_irq_ctrl u_err_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .err_evt_i(err_evt_i), .pdn_i(pdn_i),
    .reg_addr_i(reg_addr_i), .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .irq_n_o(irq_n_o), .mute_o(mute_o)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr_i = a; reg_rd_i = 1'b1;
    #1 d = reg_rdata_o;
    step();
    reg_rd_i = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr_i = a; reg_wdata_i = d; reg_wr_i = 1'b1;
    step();
    reg_wr_i = 1'b0;
  endtask

  // one-cycle pulse; returns just after the edge that records it
  task automatic pulse(input int src);
    err_evt_i[src] = 1'b1;
    step();
    err_evt_i[src] = 1'b0;
    step();
  endtask

  task automatic pdn_cycle();
    pdn_i = 4'hF; step();
    pdn_i = 4'h0; step();
  endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    rst_n = 1'b0; err_evt_i = '0; pdn_i = '0; reg_addr_i = '0;
    reg_wr_i = 1'b0; reg_rd_i = 1'b0; reg_wdata_i = '0;
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R9 reset state
    check("R9 irq_n", irq_n_o, 1);
    check("R9 mute", mute_o, 0);
    rd(2'd1, d); check("R9 mask", d, 0);
    rd(2'd0, d); check("R9 notif", d, 0);

    // R10 mask register and ignored notification write
    wr(2'd1, 8'hFF);
    rd(2'd1, d); check("R10 mask width", d, 8'h1F);
    wr(2'd1, 8'h15);
    rd(2'd1, d); check("R10 mask rw", d, 8'h15);
    wr(2'd0, 8'hFF);
    rd(2'd0, d); check("R10 notif write ignored", d, 0);
    check("R10 irq after notif write", irq_n_o, 1);

    // Sweep: every source with mask set and clear (R1 R3 R4 R5 R7 R8)
    for (int s = 0; s < 5; s++) begin
      for (int m = 0; m < 2; m++) begin
        logic is_mute;
        is_mute = (s == 1) || (s == 2);
        wr(2'd1, m ? (8'h1 << s) : 8'h00);
        check("R1 no early flag irq", irq_n_o, 1);
        err_evt_i[s] = 1'b1;
        step();
        err_evt_i[s] = 1'b0;
        check("R1 not yet recorded irq", irq_n_o, 1);
        step();
        check("R4 irq vs mask", irq_n_o, m ? 1 : 0);
        check("R7 mute by source", mute_o, is_mute);
        rd(2'd0, d); check("R3 flag recorded", d, 8'h1 << s);
        check("R5 irq after clear", irq_n_o, 1);
        rd(2'd0, d); check("R5 cleared", d, 0);
        if (is_mute) begin
          check("R8 mute held after read", mute_o, 1);
          pdn_i = 4'h7; step();
          pdn_i = 4'h0; step();
          check("R8 partial set keeps mute", mute_o, 1);
          pdn_i = 4'hF; step();
          check("R8 all set keeps mute", mute_o, 1);
          pdn_i = 4'hB; step();
          check("R8 partial clear keeps mute", mute_o, 1);
          pdn_i = 4'h0; step();
          check("R8 released", mute_o, 0);
        end
      end
    end
    wr(2'd1, 8'h00);

    // R2 held-high input sets once
    err_evt_i[3] = 1'b1;
    step(); step();
    rd(2'd0, d); check("R2 first record", d, 8'h08);
    repeat (4) step();
    rd(2'd0, d); check("R2 no re-record while held", d, 0);
    check("R2 irq quiet while held", irq_n_o, 1);
    err_evt_i[3] = 1'b0;
    step(); step();
    rd(2'd0, d); check("R2 falling edge ignored", d, 0);

    // R6 edge wins against same-cycle clear
    pulse(3);
    err_evt_i[0] = 1'b1;
    step();
    rd(2'd0, d); check("R6 read value before collision", d, 8'h08);
    err_evt_i[0] = 1'b0;
    rd(2'd0, d); check("R6 edge survives clear", d, 8'h01);
    check("R6 irq after collision cleared", irq_n_o, 1);

    // R11 restart during recovery
    pulse(1);
    check("R11 mute on", mute_o, 1);
    pdn_i = 4'hF; step();
    err_evt_i[2] = 1'b1;
    step();
    pdn_i = 4'h0;
    step();
    err_evt_i[2] = 1'b0;
    check("R11 restarted mute", mute_o, 1);
    step(); step();
    check("R11 low alone does not release", mute_o, 1);
    pdn_cycle();
    check("R11 released after fresh cycle", mute_o, 0);
    rd(2'd0, d); check("R11 flags", d, 8'h06);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule